// File: doc/BRIEF.md
# Sticky Interrupt Status Gate

This block collects the interrupt sources of a serial flash controller onto one interrupt line. Event pulses from the transfer engine and conditions derived from the transmit and receive FIFO fill levels are captured into sticky status bits. Two mask registers qualify those bits. A record mask decides which events are captured at all. A line mask decides which captured bits may drive the interrupt output.

Software reaches the block through a small word-addressed register port. Writes take effect at the clock edge and reads are combinational. Status bits are cleared by writing ones. The block also holds the two FIFO threshold values that produce the threshold events. A soft reset command returns the masks and thresholds to zero. That command also leaves the FIFO-empty status bits pending, so the empty state is seen once the masks are opened again.

Top module: `irq_status_gate`

## Requirements
- R1: After rst_n is released, every register reads zero, status is zero and irq is low.
- R2: Status bit positions: 0 tx empty, 1 tx full, 2 tx threshold, 3 rx empty, 4 rx full, 5 rx threshold, 9 descriptor done, 10 packet done, 11 DMA error. An event is captured into its bit only while the matching bit of the record mask (address 0) is set.
- R3: A captured status bit stays set after its event goes away.
- R4: Writing address 2 clears each status bit whose data bit is one. Bits written with zero are unchanged.
- R5: When an enabled event arrives in the same cycle as a clear of its bit, the bit stays set.
- R6: irq is high exactly when some status bit is set in the record mask and in the line mask (address 1). irq follows the registers with no extra delay.
- R7: Reading address 2 returns status ANDed with the record mask. A bit hidden by clearing its mask bit is kept and shows again when the mask bit is set.
- R8: Only bits 0-5 and 9-11 of the masks are writable (0xE3F). Address 3 holds the tx threshold in bits [12:8] and the rx threshold in bits [4:0]. All other bits read zero.
- R9: The tx threshold event is active while tx_level <= tx threshold. The rx threshold event is active while rx_level >= rx threshold.
- R10: The empty events are active while a level is 0. The full events are active while a level equals FIFO_DEPTH.
- R11: Writing bit 0 of address 4 is a soft reset. It zeroes both masks and both thresholds and sets status to exactly 0x009 (tx empty and rx empty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Word address: 0 record mask, 1 line mask, 2 status, 3 thresholds, 4 control |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr, combinational |
| evt_bd_done | input | 1 | Descriptor done pulse |
| evt_pkt_done | input | 1 | Packet done pulse |
| evt_dma_err | input | 1 | DMA error pulse |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| irq | output | 1 | Interrupt line |

## Verification
An event, level condition or register write present before a clock edge shows in the status read and on irq right after that edge, one register stage later. A mask change moves irq in the same step, because irq is combinational from the registers. The bench drives inputs just after a rising edge and samples reg_rdata and irq at the next falling edge. Its reference model advances on each rising edge, so model and design are compared at the same point on every clock.

// File: rtl/irq_status_gate.sv
module irq_status_gate #(
  parameter int DW         = 32,
  parameter int AW         = 3,
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             evt_bd_done,
  input  logic             evt_pkt_done,
  input  logic             evt_dma_err,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  output logic             irq
);
  localparam int NB    = 12;
  localparam int THR_W = 5;
  localparam int CW    = (LVL_W > THR_W) ? LVL_W : THR_W;
  localparam logic [NB-1:0] VALID  = 12'hE3F;
  localparam logic [NB-1:0] SRST_V = 12'h009;
  localparam logic [AW-1:0] A_EN  = AW'(0);
  localparam logic [AW-1:0] A_SIG = AW'(1);
  localparam logic [AW-1:0] A_ST  = AW'(2);
  localparam logic [AW-1:0] A_THR = AW'(3);
  localparam logic [AW-1:0] A_CTL = AW'(4);
  localparam logic [CW-1:0] FULL  = CW'(FIFO_DEPTH);

  logic [NB-1:0]    en_q, sig_q, st_q, ev_raw, clr;
  logic [THR_W-1:0] tthr_q, rthr_q;
  logic [CW-1:0]    txl, rxl, tthr_x, rthr_x;
  logic             soft_wr;

  assign txl    = CW'(tx_level);
  assign rxl    = CW'(rx_level);
  assign tthr_x = CW'(tthr_q);
  assign rthr_x = CW'(rthr_q);

  assign ev_raw = {evt_dma_err, evt_pkt_done, evt_bd_done, 3'b000,
                   rxl >= rthr_x, rxl == FULL, rxl == '0,
                   txl <= tthr_x, txl == FULL, txl == '0};

  assign soft_wr = reg_we && reg_addr == A_CTL && reg_wdata[0];
  assign clr     = (reg_we && reg_addr == A_ST) ? (reg_wdata[NB-1:0] & VALID) : '0;
  assign irq     = |(st_q & en_q & sig_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      sig_q  <= '0;
      st_q   <= '0;
      tthr_q <= '0;
      rthr_q <= '0;
    end else if (soft_wr) begin
      en_q   <= '0;
      sig_q  <= '0;
      st_q   <= SRST_V;
      tthr_q <= '0;
      rthr_q <= '0;
    end else begin
      if (reg_we && reg_addr == A_EN)  en_q  <= reg_wdata[NB-1:0] & VALID;
      if (reg_we && reg_addr == A_SIG) sig_q <= reg_wdata[NB-1:0] & VALID;
      if (reg_we && reg_addr == A_THR) begin
        tthr_q <= reg_wdata[8 +: THR_W];
        rthr_q <= reg_wdata[0 +: THR_W];
      end
      st_q <= (st_q & ~clr) | (ev_raw & en_q);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EN:    reg_rdata = DW'(en_q);
      A_SIG:   reg_rdata = DW'(sig_q);
      A_ST:    reg_rdata = DW'(st_q & en_q);
      A_THR:   reg_rdata = DW'({tthr_q, 3'b000, rthr_q});
      default: reg_rdata = '0;
    endcase
  end
endmodule

module irq_status_gate_chk #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          evt_bd_done,
  input logic          evt_dma_err,
  input logic [11:0]   en_q,
  input logic [11:0]   sig_q,
  input logic [11:0]   st_q,
  input logic          irq
);
  logic st_wr, sr_wr;
  assign st_wr = reg_we && reg_addr == AW'(2);
  assign sr_wr = reg_we && reg_addr == AW'(4) && reg_wdata[0];

  assert_masked_not_recorded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[9] && !st_q[9] && !sr_wr) |=> !st_q[9]);

  assert_status_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[10] && !(st_wr && reg_wdata[10]) && !sr_wr) |=> st_q[10]);

  assert_write_one_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && reg_wdata[9] && !evt_bd_done) |=> !st_q[9]);

  assert_event_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && reg_wdata[11] && evt_dma_err && en_q[11]) |=> st_q[11]);

  assert_irq_needs_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != 12'h000 && sig_q != 12'h000));

  assert_soft_reset_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr |=> (en_q == 12'h000 && sig_q == 12'h000 && st_q == 12'h009));
endmodule

bind irq_status_gate irq_status_gate_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .evt_bd_done(evt_bd_done), .evt_dma_err(evt_dma_err),
  .en_q(en_q), .sig_q(sig_q), .st_q(st_q), .irq(irq));

// File: tb/irq_status_gate_tb_top.sv
`timescale 1ns/1ps
module irq_status_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, AW = 3, DEPTH = 16, LVL_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic evt_bd_done = 1'b0, evt_pkt_done = 1'b0, evt_dma_err = 1'b0;
  logic [LVL_W-1:0] tx_level = 5'd5, rx_level = 5'd3;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  int m_en = 0, m_sig = 0, m_st = 0, m_tthr = 0, m_rthr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_gate #(.DW(DW), .AW(AW), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_bd_done(evt_bd_done),
    .evt_pkt_done(evt_pkt_done), .evt_dma_err(evt_dma_err),
    .tx_level(tx_level), .rx_level(rx_level), .irq(irq));

  function automatic int model_read(int a);
    case (a)
      0: return m_en;
      1: return m_sig;
      2: return m_st & m_en;
      3: return (m_tthr << 8) | m_rthr;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_sig = 0; m_st = 0; m_tthr = 0; m_rthr = 0;
    end else begin
      int ev, tx, rx, a, d;
      tx = int'(tx_level); rx = int'(rx_level);
      a = int'(reg_addr); d = int'(reg_wdata);
      ev = 0;
      if (tx == 0) ev += 1;
      if (tx == DEPTH) ev += 2;
      if (tx <= m_tthr) ev += 4;
      if (rx == 0) ev += 8;
      if (rx == DEPTH) ev += 16;
      if (rx >= m_rthr) ev += 32;
      if (evt_bd_done) ev += 512;
      if (evt_pkt_done) ev += 1024;
      if (evt_dma_err) ev += 2048;
      if (reg_we && a == 4 && (d % 2) == 1) begin
        m_en = 0; m_sig = 0; m_st = 9; m_tthr = 0; m_rthr = 0;
      end else begin
        int nst;
        nst = m_st;
        if (reg_we && a == 2) nst = nst & ~(d & 'hE3F);
        nst = nst | (ev & m_en);
        if (reg_we && a == 0) m_en = d & 'hE3F;
        if (reg_we && a == 1) m_sig = d & 'hE3F;
        if (reg_we && a == 3) begin
          m_tthr = (d >> 8) & 31;
          m_rthr = d & 31;
        end
        m_st = nst;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Every clock: interrupt line (R6) and read port (R7) against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 irq per-clock", int'(irq), ((m_st & m_en & m_sig) != 0) ? 1 : 0);
      chk("R7 rdata per-clock", int'(reg_rdata), model_read(int'(reg_addr)));
    end
  end

  task automatic wr(int a, int d);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(string req, int a, int exp);
    reg_addr = AW'(a);
    @(negedge clk);
    chk(req, int'(reg_rdata), exp);
    @(posedge clk); #1;
  endtask

  task automatic irq_chk(string req, int exp);
    @(negedge clk);
    chk(req, int'(irq), exp);
    @(posedge clk); #1;
  endtask

  task automatic tx_blip(int lvl);
    tx_level = LVL_W'(lvl);
    @(posedge clk); #1;
    tx_level = 5'd5;
  endtask

  task automatic rx_blip(int lvl);
    rx_level = LVL_W'(lvl);
    @(posedge clk); #1;
    rx_level = 5'd3;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    for (int a = 0; a < 5; a++) rd_chk("R1 reset read", a, 0);
    irq_chk("R1 reset irq", 0);

    wr(3, 'hFFFFE2F4);
    rd_chk("R8 threshold fields", 3, 'h214);

    evt_bd_done = 1'b1; @(posedge clk); #1; evt_bd_done = 1'b0;
    wr(0, 'hFFFFFFFF);
    rd_chk("R8 record mask writable bits", 0, 'hE3F);
    rd_chk("R2 event with mask off not captured", 2, 0);

    evt_bd_done = 1'b1; @(posedge clk); #1; evt_bd_done = 1'b0;
    rd_chk("R2 descriptor done at bit 9", 2, 'h200);
    rd_chk("R3 bit held after pulse", 2, 'h200);
    irq_chk("R6 line mask zero keeps irq low", 0);
    wr(1, 'h200);
    irq_chk("R6 irq raised by line mask", 1);
    wr(1, 'h400);
    irq_chk("R6 other line bit no irq", 0);

    wr(2, 0);
    rd_chk("R4 zero write keeps bit", 2, 'h200);
    wr(2, 'h200);
    rd_chk("R4 one write clears bit", 2, 0);

    evt_bd_done = 1'b1; reg_we = 1'b1; reg_addr = AW'(2); reg_wdata = DW'('h200);
    @(posedge clk); #1;
    evt_bd_done = 1'b0; reg_we = 1'b0;
    rd_chk("R5 event wins over clear", 2, 'h200);

    wr(0, 0);
    rd_chk("R7 masked bit reads zero", 2, 0);
    wr(1, 'h200);
    irq_chk("R7 masked bit no irq", 0);
    wr(0, 'hE3F);
    rd_chk("R7 hidden bit reappears", 2, 'h200);
    irq_chk("R6 irq with both masks", 1);
    wr(2, 'hFFF);
    rd_chk("R4 clear all", 2, 0);

    tx_blip(2);
    rd_chk("R9 tx at threshold", 2, 'h004);
    wr(2, 'hFFF);
    tx_blip(3);
    rd_chk("R9 tx above threshold", 2, 0);
    rx_blip(20);
    rd_chk("R9 rx at threshold", 2, 'h020);
    wr(2, 'hFFF);
    rx_blip(19);
    rd_chk("R9 rx below threshold", 2, 0);

    tx_blip(0);
    rd_chk("R10 tx empty", 2, 'h005);
    wr(2, 'hFFF);
    tx_blip(16);
    rd_chk("R10 tx full", 2, 'h002);
    wr(2, 'hFFF);
    rx_blip(0);
    rd_chk("R10 rx empty", 2, 'h008);
    wr(2, 'hFFF);
    rx_blip(16);
    rd_chk("R10 rx full", 2, 'h010);
    wr(2, 'hFFF);

    evt_pkt_done = 1'b1; evt_dma_err = 1'b1;
    @(posedge clk); #1;
    evt_pkt_done = 1'b0; evt_dma_err = 1'b0;
    rd_chk("R2 packet done and error bits", 2, 'hC00);

    wr(4, 1);
    rd_chk("R11 record mask zeroed", 0, 0);
    rd_chk("R11 line mask zeroed", 1, 0);
    rd_chk("R11 thresholds zeroed", 3, 0);
    irq_chk("R11 no irq after soft reset", 0);
    wr(0, 'h009);
    rd_chk("R11 empty bits pending", 2, 'h009);

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule